// File: doc/BRIEF.md
# Bridge Link Status Width and Speed Clamp

This block keeps the link status word of a bridge port. On a one-cycle update strobe it rewrites the negotiated-width and current-speed fields of that word. All other bits of the word are left alone. The new values come from the link status that the device below the bridge reports, limited to what the bridge's own link capability advertises.

When the downstream side has no usable device, the capability values are used instead. A usable device is one that is present and carries an express capability. A downstream field of zero is read as "not reported" and is replaced by the minimum legal value: a x1 width, or the 2.5 GT/s speed code.

The status word can also be loaded as a whole through a load strobe. This is how the bits outside the two fields get their values.

Top module: `lnk_sta_clamp`

## Requirements
- R1: After reset the status word reads all zeros.
- R2: On an update with `dn_ok_i` low, the width field (bits [9:4]) takes `cap_wid_i` and the speed field (bits [3:0]) takes `cap_spd_i`, whatever the downstream fields hold.
- R3: On an update with `dn_ok_i` high and `dn_wid_i` greater than `cap_wid_i`, the width field takes `cap_wid_i`.
- R4: On an update with `dn_ok_i` high and `dn_wid_i` equal to zero, the width field takes 1 (x1).
- R5: On an update with `dn_ok_i` high and `dn_wid_i` nonzero and not above `cap_wid_i`, the width field takes `dn_wid_i`. The same pass-through applies to the speed field when `dn_spd_i` is nonzero and not above `cap_spd_i`.
- R6: On an update with `dn_ok_i` high and `dn_spd_i` greater than `cap_spd_i`, the speed field takes `cap_spd_i`.
- R7: On an update with `dn_ok_i` high and `dn_spd_i` equal to zero, the speed field takes 1 (the 2.5 GT/s code).
- R8: An update without a load leaves bits [15:10] of the status word unchanged.
- R9: In a cycle with neither update nor load, the status word holds its value.
- R10: A load writes `sta_din_i` into the whole word. If an update occurs in the same cycle, bits [15:10] come from `sta_din_i` and bits [9:0] come from the clamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_i | input | 1 | One-cycle strobe that rewrites the width and speed fields |
| dn_ok_i | input | 1 | A downstream device is present and has an express capability |
| cap_wid_i | input | 6 | Bridge maximum link width from its capability |
| cap_spd_i | input | 4 | Bridge maximum supported speed code from its capability |
| dn_wid_i | input | 6 | Negotiated width reported downstream |
| dn_spd_i | input | 4 | Current speed code reported downstream |
| ld_i | input | 1 | Load the whole status word |
| sta_din_i | input | 16 | Value for the load |
| sta_o | output | 16 | Bridge link status word |

## Verification
Every result is due exactly one clock edge after its strobe: the word is a single register and has no pipeline in front of it. The bench changes inputs on the falling edge, lets one rising edge pass, and reads `sta_o` on the following falling edge. That is one cycle after the strobe, and never at the edge itself. The hold check leaves a full idle cycle and compares the word against its previous value, so a stray write would show up.

// File: rtl/lnk_sta_clamp.sv
module lnk_sta_clamp #(
  parameter int SPD_W = 4,
  parameter int WID_W = 6,
  parameter int STA_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_i,
  input  logic             dn_ok_i,
  input  logic [WID_W-1:0] cap_wid_i,
  input  logic [SPD_W-1:0] cap_spd_i,
  input  logic [WID_W-1:0] dn_wid_i,
  input  logic [SPD_W-1:0] dn_spd_i,
  input  logic             ld_i,
  input  logic [STA_W-1:0] sta_din_i,
  output logic [STA_W-1:0] sta_o
);
  localparam int FLD_W = SPD_W + WID_W;
  localparam logic [WID_W-1:0] WID_X1 = WID_W'(1);
  localparam logic [SPD_W-1:0] SPD_MIN = SPD_W'(1);

  logic [WID_W-1:0] wid_new;
  logic [SPD_W-1:0] spd_new;
  logic [STA_W-1:0] base;
  logic [STA_W-1:0] sta_q;

  assign wid_new = !dn_ok_i               ? cap_wid_i :
                   (dn_wid_i > cap_wid_i) ? cap_wid_i :
                   (dn_wid_i == '0)       ? WID_X1    : dn_wid_i;

  assign spd_new = !dn_ok_i               ? cap_spd_i :
                   (dn_spd_i > cap_spd_i) ? cap_spd_i :
                   (dn_spd_i == '0)       ? SPD_MIN   : dn_spd_i;

  assign base = ld_i ? sta_din_i : sta_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      sta_q <= '0;
    else if (upd_i)
      sta_q <= {base[STA_W-1:FLD_W], wid_new, spd_new};
    else if (ld_i)
      sta_q <= sta_din_i;
  end

  assign sta_o = sta_q;
endmodule

// File: rtl/lnk_sta_clamp_chk.sv
module lnk_sta_clamp_chk #(
  parameter int SPD_W = 4,
  parameter int WID_W = 6,
  parameter int STA_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             upd_i,
  input logic             dn_ok_i,
  input logic [WID_W-1:0] cap_wid_i,
  input logic [SPD_W-1:0] cap_spd_i,
  input logic [WID_W-1:0] dn_wid_i,
  input logic [SPD_W-1:0] dn_spd_i,
  input logic             ld_i,
  input logic [STA_W-1:0] sta_o
);
  localparam int FLD_W = SPD_W + WID_W;

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_i && !ld_i) |=> $stable(sta_o));

  // R8
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && !ld_i) |=> sta_o[STA_W-1:FLD_W] == $past(sta_o[STA_W-1:FLD_W]));

  // R2
  no_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && !dn_ok_i) |=> sta_o[FLD_W-1:0] == $past({cap_wid_i, cap_spd_i}));

  // R3
  wid_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && dn_ok_i && dn_wid_i > cap_wid_i) |=> sta_o[FLD_W-1:SPD_W] == $past(cap_wid_i));

  // R4
  wid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && dn_ok_i && dn_wid_i == '0) |=> sta_o[FLD_W-1:SPD_W] == WID_W'(1));

  // R6
  spd_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && dn_ok_i && dn_spd_i > cap_spd_i) |=> sta_o[SPD_W-1:0] == $past(cap_spd_i));

  // R7
  spd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && dn_ok_i && dn_spd_i == '0) |=> sta_o[SPD_W-1:0] == SPD_W'(1));
endmodule

bind lnk_sta_clamp lnk_sta_clamp_chk #(.SPD_W(SPD_W), .WID_W(WID_W), .STA_W(STA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .dn_ok_i(dn_ok_i),
  .cap_wid_i(cap_wid_i), .cap_spd_i(cap_spd_i), .dn_wid_i(dn_wid_i),
  .dn_spd_i(dn_spd_i), .ld_i(ld_i), .sta_o(sta_o)
);

// File: tb/lnk_sta_clamp_test.sv
module lnk_sta_clamp_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd = 1'b0, ok = 1'b0, ld = 1'b0;
  logic [5:0] capw = '0, dnw = '0;
  logic [3:0] caps = '0, dns = '0;
  logic [15:0] din = '0;
  logic [15:0] sta;
  int n_run = 0, n_bad = 0;

  always #2 clk = ~clk;

  lnk_sta_clamp uut (
    .clk(clk), .rst_n(rst_n), .upd_i(upd), .dn_ok_i(ok),
    .cap_wid_i(capw), .cap_spd_i(caps), .dn_wid_i(dnw), .dn_spd_i(dns),
    .ld_i(ld), .sta_din_i(din), .sta_o(sta)
  );

  // {ok, capw, caps, dnw, dns, exp_w, exp_s}
  localparam int NV = 10;
  localparam logic [30:0] VEC [NV] = '{
    {1'b0, 6'd8,  4'd3, 6'd4,  4'd2,  6'd8,  4'd3},  // R2
    {1'b1, 6'd8,  4'd3, 6'd4,  4'd2,  6'd4,  4'd2},  // R5
    {1'b1, 6'd8,  4'd3, 6'd16, 4'd2,  6'd8,  4'd2},  // R3
    {1'b1, 6'd8,  4'd3, 6'd0,  4'd2,  6'd1,  4'd2},  // R4
    {1'b1, 6'd8,  4'd3, 6'd4,  4'd5,  6'd4,  4'd3},  // R6
    {1'b1, 6'd8,  4'd3, 6'd4,  4'd0,  6'd4,  4'd1},  // R7
    {1'b1, 6'd4,  4'd2, 6'd0,  4'd0,  6'd1,  4'd1},  // R4 R7
    {1'b1, 6'd16, 4'd4, 6'd16, 4'd4,  6'd16, 4'd4},  // R5 equal bound
    {1'b1, 6'd1,  4'd1, 6'd32, 4'd15, 6'd1,  4'd1},  // R3 R6
    {1'b0, 6'd2,  4'd5, 6'd0,  4'd0,  6'd2,  4'd5}   // R2
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(input logic u, input logic l);
    upd = u; ld = l;
    @(negedge clk);
    upd = 1'b0; ld = 1'b0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] prev;
    repeat (3) @(negedge clk);
    check("R1", sta, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    din = 16'hA800;
    cyc(1'b0, 1'b1);
    check("R10 load", sta, 16'hA800);

    for (int i = 0; i < NV; i++) begin
      {ok, capw, caps, dnw, dns} = VEC[i][30:10];
      cyc(1'b1, 1'b0);
      check($sformatf("R2-R8 vec%0d", i), sta, {6'b101010, VEC[i][9:0]});
    end

    // R9: idle cycles leave the word alone even with new inputs
    prev = sta;
    ok = 1'b1; capw = 6'd32; caps = 4'd4; dnw = 6'd8; dns = 4'd2;
    cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b0);
    check("R9", sta, prev);

    // R8: update after a load of all-ones upper bits
    din = 16'hFFFF;
    cyc(1'b0, 1'b1);
    cyc(1'b1, 1'b0);
    check("R8", sta, {6'h3F, 6'd8, 4'd2});

    // R10: load and update together
    din = 16'h5555;
    dnw = 6'd0; dns = 4'd9;
    cyc(1'b1, 1'b1);
    check("R10 both", sta, {6'b010101, 6'd1, 4'd4});

    // R1: reset again clears the word
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 rerun", sta, 16'h0000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule